// File: doc/BRIEF.md
# Hash Unit Error Interrupt Controller

This block watches the control side of a message-digest hashing unit for faults. It sees writes to the key, key-size, data-size and mode registers, the unit's busy flag, the address decode of every register access, and pushes into the input FIFO. It decides in the cycle of the event whether that event is an error. Each error kind has a fixed bit in a 64-bit sticky status register, and each can be suppressed by the bit at the same position in a 64-bit mask register.

An unmasked error records itself in the status register, raises the error interrupt and requests that hashing stop. Software reads the status and mask registers through a one-bit-addressed register port. It clears a status bit by writing 1 to it, and it can change the mask at any time. The interrupt follows the unmasked status bits. The halt request follows all status bits, masked or not.

Top module: `hash_err_irq`

## Requirements
- R1: After a synchronous reset the status register reads 0, the mask register reads 0x3000, and irq and halt are low.
- R2: Status bit 53 sets when key_wr, ksz_wr or dsz_wr is high while busy is high.
- R3: Status bit 54 sets when ksz_wr writes a key length above 64 bytes; a length of exactly 64 sets nothing.
- R4: Status bit 55 sets when dsz_wr writes a bit count whose low 9 bits are not all zero while the stored continue flag is 1. With the flag at 0, no bit count is an error.
- R5: Every mode_wr stores mode_val bit 2 as the continue flag, used from the next cycle. Status bit 56 sets when mode_val[1:0] equals 3 or any of mode_val[7:3] is 1.
- R6: Status bit 57 sets when bus_acc is high and addr_ok is low.
- R7: Status bit 61 sets when fifo_push is high while fifo_full is high.
- R8: An error whose mask bit (same position) is 1 changes neither the status register nor irq.
- R9: Status bits are sticky and clear on a status write (csr_sel=0) with a 1 in that bit. A new error in the same cycle wins over the clear.
- R10: Every status bit other than 53–57 and 61 always reads 0.
- R11: irq is 1 exactly when some status bit is set whose mask bit is 0. It updates in the same cycle as the status register and mask changes.
- R12: halt is 1 exactly when any status bit is set.
- R13: csr_rdata returns the status register (csr_sel=0) or the mask register (csr_sel=1) one cycle after csr_sel is presented. A mask write (csr_sel=1, csr_wr=1) loads all 64 bits of csr_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_wr | input | 1 | Key register write strobe |
| ksz_wr | input | 1 | Key length register write strobe |
| ksz_val | input | 8 | Key length written, in bytes |
| dsz_wr | input | 1 | Data length register write strobe |
| dsz_val | input | 16 | Data length written, in bits |
| mode_wr | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Mode value written |
| busy | input | 1 | Unit is hashing |
| bus_acc | input | 1 | A register access hits the unit's space |
| addr_ok | input | 1 | That access decodes to a real register |
| fifo_push | input | 1 | Input FIFO push |
| fifo_full | input | 1 | Input FIFO full |
| csr_sel | input | 1 | 0 selects status, 1 selects mask |
| csr_wr | input | 1 | Register port write strobe |
| csr_wdata | input | 64 | Register port write data |
| csr_rdata | output | 64 | Registered read data |
| irq | output | 1 | Error interrupt |
| halt | output | 1 | Halt request to the hashing unit |

## Verification
The bench targets the boundaries of the checks. A key length of 64 against 65 tests the comparison: a design using the wrong comparison flags a legal key. A data length that is fine with the continue flag clear becomes an error once the flag is set. A design that used the incoming mode value instead of the stored flag would judge that case wrongly. A clear and a new error on the same bit in one cycle tests which wins: a design where the clear wins loses the error. A mask set after an error has latched tests the two outputs: irq must drop while halt stays high, so a design that tied halt to irq would release the unit too early.

// File: rtl/hue_pkg.sv
`timescale 1ns/1ps
package hue_pkg;
  localparam int STAT_W    = 64;
  localparam int B_CTX     = 53;
  localparam int B_KEYLEN  = 54;
  localparam int B_DATALEN = 55;
  localparam int B_MODE    = 56;
  localparam int B_ADDR    = 57;
  localparam int B_OVF     = 61;
  localparam logic [STAT_W-1:0] LIVE_BITS =
      (64'd1 << B_CTX) | (64'd1 << B_KEYLEN) | (64'd1 << B_DATALEN) |
      (64'd1 << B_MODE) | (64'd1 << B_ADDR) | (64'd1 << B_OVF);
  localparam logic [STAT_W-1:0] MASK_INIT = 64'h3000;
  typedef enum logic { SEL_STATUS = 1'b0, SEL_MASK = 1'b1 } csr_sel_e;
endpackage

// File: rtl/hue_err_detect.sv
`timescale 1ns/1ps
module hue_err_detect
  import hue_pkg::*;
#(
  parameter int KSZ_W    = 8,
  parameter int DSZ_W    = 16,
  parameter int MODE_W   = 8,
  parameter int KEY_MAX  = 64,
  parameter int BLK_BITS = 512,
  parameter int ALG_W    = 2,
  parameter int ALG_MAX  = 2,
  parameter int CONT_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic              ksz_wr,
  input  logic [KSZ_W-1:0]  ksz_val,
  input  logic              dsz_wr,
  input  logic [DSZ_W-1:0]  dsz_val,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_val,
  input  logic              busy,
  input  logic              bus_acc,
  input  logic              addr_ok,
  input  logic              fifo_push,
  input  logic              fifo_full,
  output logic [STAT_W-1:0] err_vec
);
  localparam int                BLK_LSB = $clog2(BLK_BITS);
  localparam int                RSV_LSB = CONT_BIT + 1;
  localparam logic [KSZ_W-1:0]  KEY_LIM = KSZ_W'(KEY_MAX);
  localparam logic [ALG_W-1:0]  ALG_LIM = ALG_W'(ALG_MAX);

  logic cont_q;
  logic rsv_hit, alg_bad, len_odd;

  // continue flag: captured from every mode write, legal or not
  always_ff @(posedge clk) begin
    if (rst)          cont_q <= 1'b0;
    else if (mode_wr) cont_q <= mode_val[CONT_BIT];
  end

  always_comb begin
    rsv_hit = (mode_val >> RSV_LSB) != '0;
    alg_bad = mode_val[ALG_W-1:0] > ALG_LIM;
    len_odd = dsz_val[BLK_LSB-1:0] != '0;
    err_vec = '0;
    err_vec[B_CTX]     = busy & (key_wr | ksz_wr | dsz_wr);
    err_vec[B_KEYLEN]  = ksz_wr & (ksz_val > KEY_LIM);
    err_vec[B_DATALEN] = dsz_wr & cont_q & len_odd;
    err_vec[B_MODE]    = mode_wr & (rsv_hit | alg_bad);
    err_vec[B_ADDR]    = bus_acc & ~addr_ok;
    err_vec[B_OVF]     = fifo_push & fifo_full;
  end

  AST_CONT_TRACK: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> cont_q == $past(mode_val[CONT_BIT])); // R5
  AST_ERR_LIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (err_vec & ~LIVE_BITS) == '0); // R10
endmodule

// File: rtl/hue_status_reg.sv
`timescale 1ns/1ps
module hue_status_reg
  import hue_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] err_vec,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq_q,
  output logic              halt_q
);
  logic [STAT_W-1:0] clr_bits, set_bits, status_n, mask_n;

  always_comb begin
    clr_bits = clr_we ? wdata : '0;
    set_bits = err_vec & ~mask_q;
    status_n = ((status_q & ~clr_bits) | set_bits) & LIVE_BITS;
    mask_n   = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= MASK_INIT;
      irq_q    <= 1'b0;
      halt_q   <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      irq_q    <= |(status_n & ~mask_n);
      halt_q   <= |status_n;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~LIVE_BITS) == '0); // R10
  AST_IRQ_NEEDS_HALT: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> halt_q); // R12
  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q & $past(err_vec & mask_q & ~status_q)) == '0); // R8
  AST_ERR_STICKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q & $past(err_vec & ~mask_q)) == $past(err_vec & ~mask_q & LIVE_BITS)); // R9
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> (status_q & $past(wdata & ~(err_vec & ~mask_q))) == '0); // R9
endmodule

// File: rtl/hue_csr_rd.sv
`timescale 1ns/1ps
module hue_csr_rd
  import hue_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)                          rdata <= '0;
    else if (csr_sel_e'(sel) == SEL_MASK) rdata <= mask;
    else                              rdata <= status;
  end

  AST_RD_STATUS: assert property (@(posedge clk) disable iff (rst)
    !sel |=> rdata == $past(status)); // R13
endmodule

// File: rtl/hash_err_irq.sv
`timescale 1ns/1ps
module hash_err_irq
  import hue_pkg::*;
#(
  parameter int KSZ_W    = 8,
  parameter int DSZ_W    = 16,
  parameter int MODE_W   = 8,
  parameter int KEY_MAX  = 64,
  parameter int BLK_BITS = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic              ksz_wr,
  input  logic [KSZ_W-1:0]  ksz_val,
  input  logic              dsz_wr,
  input  logic [DSZ_W-1:0]  dsz_val,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_val,
  input  logic              busy,
  input  logic              bus_acc,
  input  logic              addr_ok,
  input  logic              fifo_push,
  input  logic              fifo_full,
  input  logic              csr_sel,
  input  logic              csr_wr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  output logic              irq,
  output logic              halt
);
  logic [STAT_W-1:0] err_vec, status_q, mask_q;
  logic              clr_we, mask_we;

  assign clr_we  = csr_wr & (csr_sel_e'(csr_sel) == SEL_STATUS);
  assign mask_we = csr_wr & (csr_sel_e'(csr_sel) == SEL_MASK);

  hue_err_detect #(
    .KSZ_W(KSZ_W), .DSZ_W(DSZ_W), .MODE_W(MODE_W),
    .KEY_MAX(KEY_MAX), .BLK_BITS(BLK_BITS)
  ) u_detect (
    .clk(clk), .rst(rst),
    .key_wr(key_wr), .ksz_wr(ksz_wr), .ksz_val(ksz_val),
    .dsz_wr(dsz_wr), .dsz_val(dsz_val),
    .mode_wr(mode_wr), .mode_val(mode_val),
    .busy(busy), .bus_acc(bus_acc), .addr_ok(addr_ok),
    .fifo_push(fifo_push), .fifo_full(fifo_full),
    .err_vec(err_vec)
  );

  hue_status_reg u_stat (
    .clk(clk), .rst(rst), .err_vec(err_vec),
    .clr_we(clr_we), .mask_we(mask_we), .wdata(csr_wdata),
    .status_q(status_q), .mask_q(mask_q), .irq_q(irq), .halt_q(halt)
  );

  hue_csr_rd u_rd (
    .clk(clk), .rst(rst), .sel(csr_sel),
    .status(status_q), .mask(mask_q), .rdata(csr_rdata)
  );

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
    (fifo_push && fifo_full && !mask_q[B_OVF]) |=> status_q[B_OVF]); // R7
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halt && !csr_wr) |=> halt); // R12
endmodule

// File: tb/tb_hash_err_irq.sv
`timescale 1ns/1ps
module tb_hash_err_irq;
  localparam logic [63:0] LIVE = (64'd1<<53)|(64'd1<<54)|(64'd1<<55)|(64'd1<<56)|(64'd1<<57)|(64'd1<<61);

  logic clk = 1'b0, rst = 1'b1;
  logic key_wr, ksz_wr, dsz_wr, mode_wr, busy, bus_acc, addr_ok, fifo_push, fifo_full;
  logic [7:0] ksz_val, mode_val;
  logic [15:0] dsz_val;
  logic csr_sel, csr_wr;
  logic [63:0] csr_wdata, csr_rdata;
  logic irq, halt;

  int checks = 0, fails = 0;
  logic [63:0] m_stat, m_mask, rd;
  logic m_cont;

  always #4 clk = ~clk;  // 125 MHz

  hash_err_irq dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    key_wr = 0; ksz_wr = 0; dsz_wr = 0; mode_wr = 0; busy = 0;
    bus_acc = 0; addr_ok = 1; fifo_push = 0; fifo_full = 0;
    ksz_val = 0; dsz_val = 0; mode_val = 0; csr_wr = 0; csr_wdata = 0;
  endtask

  function automatic logic [63:0] calc_err();
    logic [63:0] e = '0;
    e[53] = busy & (key_wr | ksz_wr | dsz_wr);
    e[54] = ksz_wr & (ksz_val > 8'd64);
    e[55] = dsz_wr & m_cont & (dsz_val % 512 != 0);
    e[56] = mode_wr & ((mode_val[1:0] == 2'd3) | (mode_val[7:3] != 0));
    e[57] = bus_acc & ~addr_ok;
    e[61] = fifo_push & fifo_full;
    return e;
  endfunction

  // one clock with the current inputs; compares against the model
  task automatic step(input string tag);
    logic [63:0] exp_rd, nstat, nmask, clr;
    exp_rd = csr_sel ? m_mask : m_stat;
    clr   = (csr_wr && !csr_sel) ? csr_wdata : '0;
    nstat = ((m_stat & ~clr) | (calc_err() & ~m_mask)) & LIVE;
    nmask = (csr_wr && csr_sel) ? csr_wdata : m_mask;
    if (mode_wr) m_cont = mode_val[2];
    @(posedge clk); @(negedge clk);
    m_stat = nstat; m_mask = nmask;
    chk(csr_rdata == exp_rd, {tag, " R13 rdata"}, csr_rdata, exp_rd);
    chk(irq == |(nstat & ~nmask), {tag, " R11 irq"}, 64'(irq), 64'(|(nstat & ~nmask)));
    chk(halt == |nstat, {tag, " R12 halt"}, 64'(halt), 64'(|nstat));
  endtask

  task automatic rd_reg(input logic sel, output logic [63:0] v);
    idle(); csr_sel = sel; step("read"); v = csr_rdata;
  endtask

  task automatic clr_all();
    idle(); csr_sel = 0; csr_wr = 1; csr_wdata = '1; step("clear"); idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    idle(); csr_sel = 0;
    m_stat = 0; m_mask = 64'h3000; m_cont = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk(!irq && !halt, "R1 irq/halt after reset", {irq, halt}, 0);
    rd_reg(0, rd); chk(rd == 0, "R1 status reset", rd, 0);
    rd_reg(1, rd); chk(rd == 64'h3000, "R1 mask reset", rd, 64'h3000);

    idle(); ksz_wr = 1; ksz_val = 64; step("R3");
    rd_reg(0, rd); chk(rd == 0, "R3 length 64 legal", rd, 0);
    idle(); ksz_wr = 1; ksz_val = 65; step("R3");
    rd_reg(0, rd); chk(rd == 64'd1<<54, "R3 length 65", rd, 64'd1<<54);
    chk(irq, "R11 irq on error", 64'(irq), 1);
    clr_all();
    chk(!halt, "R9 W1C releases halt", 64'(halt), 0);

    idle(); busy = 1; key_wr = 1; step("R2");
    rd_reg(0, rd); chk(rd == 64'd1<<53, "R2 key write while busy", rd, 64'd1<<53);
    clr_all();

    idle(); dsz_wr = 1; dsz_val = 100; step("R4");
    rd_reg(0, rd); chk(rd == 0, "R4 odd length without continue", rd, 0);
    idle(); mode_wr = 1; mode_val = 8'h04; step("R5");
    idle(); dsz_wr = 1; dsz_val = 1024; step("R4");
    rd_reg(0, rd); chk(rd == 0, "R4 block multiple with continue", rd, 0);
    idle(); dsz_wr = 1; dsz_val = 100; step("R4");
    rd_reg(0, rd); chk(rd == 64'd1<<55, "R4 odd length with continue", rd, 64'd1<<55);
    clr_all();

    idle(); mode_wr = 1; mode_val = 8'h03; step("R5");
    rd_reg(0, rd); chk(rd == 64'd1<<56, "R5 illegal algorithm", rd, 64'd1<<56);
    clr_all();
    idle(); mode_wr = 1; mode_val = 8'h08; step("R5");
    rd_reg(0, rd); chk(rd == 64'd1<<56, "R5 reserved bit", rd, 64'd1<<56);
    clr_all();

    idle(); bus_acc = 1; addr_ok = 0; step("R6");
    rd_reg(0, rd); chk(rd == 64'd1<<57, "R6 bad address", rd, 64'd1<<57);
    clr_all();

    idle(); fifo_push = 1; step("R7");
    idle(); fifo_push = 1; fifo_full = 1; step("R7");
    rd_reg(0, rd); chk(rd == 64'd1<<61, "R7 push while full", rd, 64'd1<<61);
    clr_all();

    idle(); csr_sel = 1; csr_wr = 1; csr_wdata = 64'd1<<61; step("R8");
    idle(); fifo_push = 1; fifo_full = 1; step("R8");
    rd_reg(0, rd); chk(rd == 0, "R8 masked overflow", rd, 0);
    chk(!irq, "R8 masked no irq", 64'(irq), 0);

    idle(); csr_sel = 0; csr_wr = 1; csr_wdata = 64'd1<<57; bus_acc = 1; addr_ok = 0; step("R9");
    rd_reg(0, rd); chk(rd == 64'd1<<57, "R9 set beats clear", rd, 64'd1<<57);

    idle(); csr_sel = 1; csr_wr = 1; csr_wdata = 64'd1<<57; step("R11");
    chk(!irq && halt, "R11 masking latched bit drops irq, halt stays", {irq, halt}, 2'b01);
    idle(); csr_sel = 1; csr_wr = 1; csr_wdata = 0; step("R11");
    clr_all();

    idle(); busy = 1; key_wr = 1; ksz_wr = 1; ksz_val = 200; mode_wr = 1; mode_val = 8'hFF;
    bus_acc = 1; addr_ok = 0; fifo_push = 1; fifo_full = 1; step("R10");
    rd_reg(0, rd); chk(rd == (LIVE & ~(64'd1<<55)), "R10 only live bits", rd, LIVE & ~(64'd1<<55));
    clr_all();

    for (int i = 0; i < 3000; i++) begin
      idle();
      busy = ($urandom % 3) == 0;
      key_wr = ($urandom % 6) == 0;
      ksz_wr = ($urandom % 6) == 0; ksz_val = 8'($urandom % 80);
      dsz_wr = ($urandom % 6) == 0; dsz_val = ($urandom % 2) ? 16'(($urandom % 8) * 512) : 16'($urandom);
      mode_wr = ($urandom % 8) == 0; mode_val = ($urandom % 2) ? 8'($urandom % 8) : 8'($urandom);
      bus_acc = ($urandom % 5) == 0; addr_ok = ($urandom % 3) != 0;
      fifo_push = ($urandom % 3) == 0; fifo_full = ($urandom % 4) == 0;
      csr_sel = 1'($urandom);
      csr_wr = ($urandom % 8) == 0;
      csr_wdata = {$urandom, $urandom} & (csr_sel ? LIVE : '1);
      step("R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule